// File: doc/BRIEF.md
# ADC Control and Conversion Sequencer

This block is the register-mapped front end of a 10-bit successive-approximation converter in a small 8-bit controller. Software reaches two configuration registers and two result registers over a simple write/read bus. It selects an input channel, decides how many of the four low port pins work as analog inputs, and picks the converter clock rate. The block then divides the system clock, tests one result bit per converter clock against an external comparator, stores the result and reports completion.

A conversion starts with a two-step write sequence on the start bit. Writing the bit from 0 to 1 resets the converter, aborts any conversion in flight and drives the active-low done flag to 1. Writing it back from 1 to 0 begins a new conversion. Software can poll the done flag, or it can enable a one-cycle interrupt request. The comparator, the trial DAC and the pins themselves sit outside the block.

Top module: `adc_seq_top`

## Requirements
- R1: Control bits 2:0 select the channel. Values 0 to 3 pick input 0 to 3, and any value with bit 2 set is illegal. `mux_en` is 1 and `mux_sel` equals bits 1:0 only when the channel is legal and its pin is analog. Otherwise `mux_en` is 0 and `mux_sel` is 0.
- R2: Control bits 5:3 set the pin modes on `pin_analog`: 000 gives 0000, 001 gives 0001, 010 gives 0011, 011 gives 0111, and any 1xx value gives 1111.
- R3: When bits 5:3 are 000, `adc_pwr_en` is 0. A start sequence then runs no conversion: the done flag stays 1 and `dac_code` stays 0.
- R4: A write that takes control bit 7 from 0 to 1 sets the done flag (control bit 6) to 1 in the following cycle.
- R5: A write that takes bit 7 from 1 to 0 begins a conversion. The result is decided MSB first, one bit per converter clock, by keeping each trial bit when `cmp_in` is 1 for the code on `dac_code`. The upper 8 result bits go to address 2. The lower 2 result bits go to bits 7:6 of address 3.
- R6: Bits 1:0 at address 1 select the converter clock period: 00 is 2, 01 is 8 and 10 is 32 system clocks. The done flag reads 0 exactly 10×period+1 cycles after the finishing write. Code 11 supplies no converter clock, so the conversion never progresses.
- R7: Address 1 reads back bits 6:2 as 0. Bit 7 reads back as written and has no effect on operation.
- R8: A control write that changes bits 5:3 sets the stale flag in bit 0 of address 3. The next 0-to-1 start write clears it.
- R9: With `int_en` high, `irq` is high for exactly one cycle, in the first cycle in which the done flag reads 0. With `int_en` low, `irq` stays low.
- R10: A conversion started on an illegal or non-analog channel sets the error flag in bit 1 of address 3. It also returns result 0, and the done flag reads 0 one cycle after the finishing write. The next 0-to-1 start write clears the error flag.
- R11: A 0-to-1 start write during a conversion aborts it. The result registers keep their previous contents and `dac_code` returns to 0.
- R12: Address 0 reads back bits 5:0 and bit 7 as last written, with the done flag in bit 6.
- R13: After reset, address 0 reads 0x40, addresses 1, 2 and 3 read 0, and `adc_pwr_en` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 clock select, 2 result high, 3 result low/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| int_en | input | 1 | Interrupt enable |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | 10 | Trial code for the external DAC, 0 when idle |
| mux_sel | output | 2 | Analog multiplexer select |
| mux_en | output | 1 | Multiplexer enable: legal analog channel |
| pin_analog | output | 4 | Per-pin analog mode for the low port pins |
| adc_pwr_en | output | 1 | Converter power enable |
| irq | output | 1 | One-cycle end-of-conversion interrupt request |

## Verification
The assertions assume that `cmp_in` settles within the cycle after `dac_code`. They also assume the start bit moves only through bus writes, so that two completions can never fall on consecutive cycles. The bench meets the first assumption with a combinational ideal comparator against a fixed input level. It meets the second by writing the control register only through its bus task, which leaves at least one idle cycle between writes. It changes the pin modes or the channel only while no conversion is running, except in the abort and power-down scenarios, which test those cases on purpose.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int NPINS = 4;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CLK  = 2'd1,
    ADDR_RHI  = 2'd2,
    ADDR_RLO  = 2'd3
  } addr_e;

  typedef enum logic {
    SAR_IDLE = 1'b0,
    SAR_RUN  = 1'b1
  } sar_st_e;

  typedef struct packed {
    logic       start;
    logic [2:0] pcfg;
    logic [2:0] chan;
  } ctrl_t;

  // thermometer decode of the pin-mode field
  function automatic logic [NPINS-1:0] pins_from_cfg(input logic [2:0] cfg);
    logic [NPINS-1:0] p;
    if (cfg[2]) p = '1;
    else begin
      for (int i = 0; i < NPINS; i++) p[i] = (i < int'(cfg[1:0]));
    end
    return p;
  endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             done,
  input  logic             err_set,
  input  logic [RES_W-1:0] result,
  output ctrl_t            ctrl,
  output logic [1:0]       clk_sel,
  output logic             start_rise,
  output logic             start_fall,
  output logic             eoc_n,
  output logic             stale,
  output logic             chan_err,
  output logic [7:0]       rdata
);

  localparam int LO_W = RES_W - 8;

  ctrl_t      ctrl_q, ctrl_n;
  logic [1:0] sel_q, sel_n;
  logic       test_q, test_n;
  logic       eoc_q, eoc_n_nx;
  logic       stale_q, stale_n;
  logic       err_q, err_n;
  logic       rise_q, fall_q;
  logic       wr_ctrl, wr_clk, rise_w, fall_w, pcfg_chg;
  logic       unused_wbit;

  assign unused_wbit = bus_wdata[6];

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_clk   = bus_wr && (bus_addr == ADDR_CLK);
  assign rise_w   = wr_ctrl && bus_wdata[7] && !ctrl_q.start;
  assign fall_w   = wr_ctrl && !bus_wdata[7] && ctrl_q.start;
  assign pcfg_chg = wr_ctrl && (bus_wdata[5:3] != ctrl_q.pcfg);

  always_comb begin
    ctrl_n   = ctrl_q;
    sel_n    = sel_q;
    test_n   = test_q;
    eoc_n_nx = eoc_q;
    stale_n  = stale_q;
    err_n    = err_q;
    if (wr_ctrl) begin
      ctrl_n.start = bus_wdata[7];
      ctrl_n.pcfg  = bus_wdata[5:3];
      ctrl_n.chan  = bus_wdata[2:0];
    end
    if (wr_clk) begin
      sel_n  = bus_wdata[1:0];
      test_n = bus_wdata[7];
    end
    if (rise_w)        eoc_n_nx = 1'b1;
    else if (done)     eoc_n_nx = 1'b0;
    if (rise_w)        stale_n = 1'b0;
    else if (pcfg_chg) stale_n = 1'b1;
    if (rise_w)        err_n = 1'b0;
    else if (err_set)  err_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sel_q   <= '0;
      test_q  <= 1'b0;
      eoc_q   <= 1'b1;
      stale_q <= 1'b0;
      err_q   <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      sel_q   <= sel_n;
      test_q  <= test_n;
      eoc_q   <= eoc_n_nx;
      stale_q <= stale_n;
      err_q   <= err_n;
      rise_q  <= rise_w;
      fall_q  <= fall_w;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: rdata = {ctrl_q.start, eoc_q, ctrl_q.pcfg, ctrl_q.chan};
      ADDR_CLK:  rdata = {test_q, 5'b0, sel_q};
      ADDR_RHI:  rdata = result[RES_W-1 -: 8];
      default:   rdata = {result[LO_W-1:0], {(6-LO_W){1'b0}}, err_q, stale_q};
    endcase
  end

  assign ctrl       = ctrl_q;
  assign clk_sel    = sel_q;
  assign start_rise = rise_q;
  assign start_fall = fall_q;
  assign eoc_n      = eoc_q;
  assign stale      = stale_q;
  assign chan_err   = err_q;

endmodule

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);

  localparam int CNT_W = $clog2(DIV_C);
  localparam logic [CNT_W-1:0] LIM_A = CNT_W'(DIV_A - 1);
  localparam logic [CNT_W-1:0] LIM_B = CNT_W'(DIV_B - 1);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(DIV_C - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n, limit;
  logic             sel_ok;

  always_comb begin
    sel_ok = 1'b1;
    unique case (sel)
      2'b00:   limit = LIM_A;
      2'b01:   limit = LIM_B;
      2'b10:   limit = LIM_C;
      default: begin limit = '0; sel_ok = 1'b0; end
    endcase
  end

  assign tick = run && sel_ok && (cnt_q == limit);

  always_comb begin
    if (!run || !sel_ok) cnt_n = '0;
    else if (tick)       cnt_n = '0;
    else                 cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             launch_err,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp_in,
  output logic             busy,
  output logic [RES_W-1:0] dac_code,
  output logic             done,
  output logic             err_set,
  output logic [RES_W-1:0] result
);

  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] IDX_MSB = IDX_W'(RES_W - 1);
  localparam logic [RES_W-1:0] ONE     = {{(RES_W-1){1'b0}}, 1'b1};

  sar_st_e          st_q, st_n;
  logic [RES_W-1:0] sar_q, sar_n, res_q, res_n;
  logic [IDX_W-1:0] idx_q, idx_n;

  always_comb begin
    st_n    = st_q;
    sar_n   = sar_q;
    idx_n   = idx_q;
    res_n   = res_q;
    done    = 1'b0;
    err_set = 1'b0;
    if (abort) begin
      st_n  = SAR_IDLE;
      sar_n = '0;
    end else if (launch) begin
      if (launch_err) begin
        res_n   = '0;
        done    = 1'b1;
        err_set = 1'b1;
        st_n    = SAR_IDLE;
      end else begin
        st_n  = SAR_RUN;
        sar_n = '0;
        idx_n = IDX_MSB;
      end
    end else if ((st_q == SAR_RUN) && tick) begin
      sar_n[idx_q] = cmp_in;
      if (idx_q == '0) begin
        res_n = sar_n;
        done  = 1'b1;
        st_n  = SAR_IDLE;
      end else begin
        idx_n = idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SAR_IDLE;
      sar_q <= '0;
      idx_q <= '0;
      res_q <= '0;
    end else begin
      st_q  <= st_n;
      sar_q <= sar_n;
      idx_q <= idx_n;
      res_q <= res_n;
    end
  end

  assign busy     = (st_q == SAR_RUN);
  assign dac_code = busy ? (sar_q | (ONE << idx_q)) : '0;
  assign result   = res_q;

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             int_en,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [1:0]       mux_sel,
  output logic             mux_en,
  output logic [NPINS-1:0] pin_analog,
  output logic             adc_pwr_en,
  output logic             irq
);

  logic             rst_s1, rst_s2;
  ctrl_t            ctrl;
  logic [1:0]       clk_sel;
  logic             start_rise, start_fall, eoc_n, stale, chan_err;
  logic             busy, done, err_set, tick, chan_ok, launch, abort;
  logic             irq_q, irq_n;
  logic [RES_W-1:0] result;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  adc_seq_regs #(.RES_W(RES_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s2),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .done       (done),
    .err_set    (err_set),
    .result     (result),
    .ctrl       (ctrl),
    .clk_sel    (clk_sel),
    .start_rise (start_rise),
    .start_fall (start_fall),
    .eoc_n      (eoc_n),
    .stale      (stale),
    .chan_err   (chan_err),
    .rdata      (bus_rdata)
  );

  assign pin_analog = pins_from_cfg(ctrl.pcfg);
  assign adc_pwr_en = (ctrl.pcfg != 3'b000);
  assign chan_ok    = !ctrl.chan[2] && pin_analog[ctrl.chan[1:0]];
  assign mux_en     = chan_ok;
  assign mux_sel    = chan_ok ? ctrl.chan[1:0] : 2'b00;
  assign launch     = start_fall && adc_pwr_en;
  assign abort      = start_rise || !adc_pwr_en;

  adc_seq_clkdiv #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_div (
    .clk   (clk),
    .rst_n (rst_s2),
    .run   (busy),
    .sel   (clk_sel),
    .tick  (tick)
  );

  adc_seq_sar #(.RES_W(RES_W)) u_sar (
    .clk        (clk),
    .rst_n      (rst_s2),
    .launch     (launch),
    .launch_err (!chan_ok),
    .abort      (abort),
    .tick       (tick),
    .cmp_in     (cmp_in),
    .busy       (busy),
    .dac_code   (dac_code),
    .done       (done),
    .err_set    (err_set),
    .result     (result)
  );

  assign irq_n = done && int_en;

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) irq_q <= 1'b0;
    else         irq_q <= irq_n;
  end

  assign irq = irq_q;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_rdata,
  input logic [RES_W-1:0] dac_code,
  input logic [1:0]       mux_sel,
  input logic             mux_en,
  input logic [3:0]       pin_analog,
  input logic             adc_pwr_en,
  input logic             irq
);

  // R1
  mux_pin_analog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_en |-> pin_analog[mux_sel]);

  // R2
  pin_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_analog == 4'h0) || (pin_analog == 4'h1) || (pin_analog == 4'h3) ||
    (pin_analog == 4'h7) || (pin_analog == 4'hF));

  // R3
  pwr_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_pwr_en && $past(!adc_pwr_en)) |-> (dac_code == '0));

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9
  irq_done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && (bus_addr == 2'd0)) |-> !bus_rdata[6]);

  // R7
  clk_reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> (bus_rdata[6:2] == 5'b0));

endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .dac_code   (dac_code),
  .mux_sel    (mux_sel),
  .mux_en     (mux_en),
  .pin_analog (pin_analog),
  .adc_pwr_en (adc_pwr_en),
  .irq        (irq)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;

  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       int_en;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic [1:0] mux_sel;
  logic       mux_en;
  logic [3:0] pin_analog;
  logic       adc_pwr_en;
  logic       irq;

  int  level;
  int  checks;
  int  failures;
  bit  finished;

  adc_seq_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .int_en     (int_en),
    .cmp_in     (cmp_in),
    .dac_code   (dac_code),
    .mux_sel    (mux_sel),
    .mux_en     (mux_en),
    .pin_analog (pin_analog),
    .adc_pwr_en (adc_pwr_en),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ideal comparator
  assign cmp_in = (level >= int'(dac_code));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [3:0] exp_pins(input int cfg);
    if (cfg >= 4) return 4'hF;
    return 4'((1 << cfg) - 1);
  endfunction

  function automatic logic [7:0] ctl(input int st, input int cfg, input int ch);
    return 8'((st << 7) | (cfg << 3) | ch);
  endfunction

  // waits for the done flag; returns cycles elapsed and irq high count
  task automatic wait_done(input int limit, output int cyc, output int irqs);
    logic [7:0] r;
    cyc = 0; irqs = 0;
    rd(2'd0, r);
    while (r[6] && cyc < limit) begin
      @(negedge clk);
      cyc++;
      if (irq) irqs++;
      rd(2'd0, r);
    end
  endtask

  task automatic t_reset;
    logic [7:0] r;
    rd(2'd0, r); check("R13 ctrl reset", r, 8'h40);
    rd(2'd1, r); check("R13 clk reset", r, 0);
    rd(2'd2, r); check("R13 rhi reset", r, 0);
    rd(2'd3, r); check("R13 rlo reset", r, 0);
    check("R13 pwr reset", adc_pwr_en, 0);
    check("R13 irq reset", irq, 0);
  endtask

  task automatic t_decode;
    logic [7:0] r;
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int ch = 0; ch < 8; ch++) begin
        bit ok;
        wr(2'd0, ctl(0, cfg, ch));
        ok = (ch < 4) && exp_pins(cfg)[ch[1:0]];
        check("R2 pin modes", pin_analog, exp_pins(cfg));
        check("R1 mux enable", mux_en, ok);
        check("R1 mux select", mux_sel, ok ? ch : 0);
        check("R3 power enable", adc_pwr_en, cfg != 0);
      end
    end
    wr(2'd0, ctl(0, 3, 2));
    rd(2'd0, r);
    check("R12 ctrl readback", r & 8'hBF, ctl(0, 3, 2));
  endtask

  task automatic t_clkreg;
    logic [7:0] r;
    wr(2'd1, 8'hFE);
    rd(2'd1, r); check("R7 clk readback", r, 8'h82);
    wr(2'd1, 8'h7D);
    rd(2'd1, r); check("R7 clk readback", r, 8'h01);
  endtask

  task automatic t_conv(input int sel, input int cfg, input int ch, input int lvl, input bit ie);
    logic [7:0] r;
    int cyc, irqs, per, expv;
    per = (sel == 0) ? 2 : (sel == 1) ? 8 : 32;
    expv = (lvl > 1023) ? 1023 : lvl;
    level = lvl; int_en = ie;
    wr(2'd1, 8'(sel));
    wr(2'd0, ctl(1, cfg, ch));
    rd(2'd0, r); check("R4 done flag set", r[6], 1);
    wr(2'd0, ctl(0, cfg, ch));
    check("R1 mux during conversion", mux_sel, ch);
    wait_done(4000, cyc, irqs);
    check("R6 conversion cycles", cyc, 10 * per + 1);
    check("R9 irq count", irqs, ie ? 1 : 0);
    @(negedge clk);
    check("R9 irq drops", irq, 0);
    rd(2'd2, r); check("R5 result high", r, expv >> 2);
    rd(2'd3, r); check("R5 result low", r & 8'hC0, (expv & 3) << 6);
    check("R10 no error", r[1], 0);
    check("R11 dac idle", dac_code, 0);
  endtask

  task automatic t_noclk;
    logic [7:0] r;
    wr(2'd1, 8'h03);
    wr(2'd0, ctl(1, 4, 0));
    wr(2'd0, ctl(0, 4, 0));
    repeat (400) @(negedge clk);
    rd(2'd0, r); check("R6 no clock no done", r[6], 1);
    check("R6 no clock stuck on msb trial", dac_code, 10'h200);
    wr(2'd0, ctl(1, 4, 0));
    @(negedge clk);
    check("R11 abort idles dac", dac_code, 0);
    wr(2'd0, ctl(0, 4, 0));
  endtask

  task automatic t_abort;
    logic [7:0] r;
    t_conv(1, 4, 1, 301, 1'b0);
    level = 777;
    wr(2'd0, ctl(1, 4, 1));
    wr(2'd0, ctl(0, 4, 1));
    repeat (24) @(negedge clk);
    wr(2'd0, ctl(1, 4, 1));
    repeat (3) @(negedge clk);
    rd(2'd0, r); check("R4 abort done flag", r[6], 1);
    check("R11 abort dac idle", dac_code, 0);
    rd(2'd2, r); check("R11 result high kept", r, 301 >> 2);
    rd(2'd3, r); check("R11 result low kept", r & 8'hC0, (301 & 3) << 6);
    repeat (100) @(negedge clk);
    rd(2'd0, r); check("R11 no late completion", r[6], 1);
    wr(2'd0, ctl(0, 4, 1));
  endtask

  task automatic t_stale;
    logic [7:0] r;
    wr(2'd0, ctl(1, 4, 0));
    wr(2'd0, ctl(0, 4, 0));
    wr(2'd0, ctl(0, 4, 0));
    rd(2'd3, r); check("R8 no stale without change", r[0], 0);
    wr(2'd0, ctl(0, 2, 0));
    rd(2'd3, r); check("R8 stale set", r[0], 1);
    wr(2'd0, ctl(1, 2, 0));
    rd(2'd3, r); check("R8 stale cleared", r[0], 0);
    wr(2'd0, ctl(0, 2, 0));
  endtask

  task automatic t_error;
    logic [7:0] r;
    int cyc, irqs;
    t_conv(0, 4, 0, 1023, 1'b0);
    int_en = 1'b1;
    wr(2'd0, ctl(1, 2, 3));
    wr(2'd0, ctl(0, 2, 3));
    check("R1 non analog channel", mux_en, 0);
    wait_done(200, cyc, irqs);
    check("R10 error completes fast", cyc, 1);
    check("R9 irq on error done", irqs, 1);
    rd(2'd2, r); check("R10 zero high", r, 0);
    rd(2'd3, r); check("R10 error flag", r[1], 1);
    check("R10 zero low", r & 8'hC0, 0);
    wr(2'd0, ctl(1, 4, 5));
    rd(2'd3, r); check("R10 error cleared", r[1], 0);
    wr(2'd0, ctl(0, 4, 5));
    wait_done(200, cyc, irqs);
    rd(2'd3, r); check("R10 illegal channel error", r[1], 1);
    int_en = 1'b0;
  endtask

  task automatic t_power;
    logic [7:0] r;
    level = 500;
    wr(2'd1, 8'h00);
    wr(2'd0, ctl(1, 0, 0));
    wr(2'd0, ctl(0, 0, 0));
    check("R3 power off", adc_pwr_en, 0);
    repeat (100) @(negedge clk);
    rd(2'd0, r); check("R3 no conversion", r[6], 1);
    check("R3 dac idle", dac_code, 0);
  endtask

  initial begin
    bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    int_en = 1'b0; level = 0;
    checks = 0; failures = 0; finished = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_decode();
    t_clkreg();
    t_conv(0, 4, 0, 0, 1'b1);
    t_conv(0, 1, 0, 1023, 1'b1);
    t_conv(1, 2, 1, 514, 1'b0);
    t_conv(2, 3, 2, 683, 1'b1);
    t_conv(1, 7, 3, 2000, 1'b0);
    t_noclk();
    t_abort();
    t_stale();
    t_error();
    t_power();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule